// File: doc/BRIEF.md
# Strobe-Qualified Page Select Gate

This block sits between a page address decoder and the peripherals on a slow expansion bus. The decoder gives one active-low select per page. Each select may glitch while the address bus settles. It may also go low part-way through a strobe-high period when the processor clock is stretched, which would give the peripheral a double access. The block turns each raw select into a clean active-low select that can start only at the rising edge of the bus strobe E. The raw select must already have been low while E was low just before that edge.

All inputs are sampled by a fast sampling clock that runs synchronously with E. Each page has its own gate, and the gates are independent of one another. A clean select, once asserted, holds through the E-high period for as long as the raw select stays low. The access ends when the raw select goes high or when E falls, whichever happens first. After an access ends at the falling edge of E, a raw select that is still held low gives no second access. The raw select must go high before a new access can start.

Top module: `page_select_qualifier`

## Requirements
- R1: While `rst` is sampled high, every bit of `sel_clean_n` is 1 on the following clock.
- R2: A clean select goes low only on the clock after a rising edge of E is sampled. A rising edge means `strobe_e`=1 in this sample and 0 in the previous one. At that sample the raw select must be 0, and it must also have been 0 in the previous, E-low, sample.
- R3: A raw select that first goes low while E is high does not assert the clean select at any point in that E-high period.
- R4: A raw select pulse that lies wholly inside an E-low period, and ends before E rises, produces no access.
- R5: While the clean select is 0, E is 1 and the raw select is 0, the clean select stays 0 on the next clock.
- R6: A raw select sampled as 1 makes the clean select 1 on the next clock.
- R7: A falling edge of E makes the clean select 1 on the next clock. A raw select held low past that edge gives no further access until it has gone high.
- R8: Each page bit (bit 0 and bit 1 by default) is gated on its own. Activity on one page has no effect on any other page's clean select.
- R9: In a double access, the raw select goes low during one E-high period and stays low through the next E-low and E-high periods. This produces exactly one clean access, in the second E-high period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, synchronous with E |
| rst | input | 1 | Synchronous reset, active high |
| strobe_e | input | 1 | Slow bus strobe E, 50% duty |
| sel_raw_n | input | NUM_PAGES | Raw decoded page selects, active low, one bit per page |
| sel_clean_n | output | NUM_PAGES | Qualified page selects, active low, one bit per page |

## Verification
All results are due one clock after the sample that causes them, because the state and the output are both updated at the same edge. Assertion and release both appear on the clock that follows the rising E sample or the releasing sample. The bench applies inputs on the falling clock edge. It advances its reference model with the inputs that the rising edge just sampled, and then compares both outputs at the next falling edge, which is exactly one register stage later. Falling transitions of the clean select are also counted for each page. Each scenario's total is then checked against the one access, or no access, that the scenario should produce.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;

    // Sampled view of the bus strobe
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } strobe_evt_t;

    // Per-page gate states
    typedef enum logic [1:0] {
        GATE_IDLE   = 2'd0,  // no candidate select
        GATE_ARMED  = 2'd1,  // raw select low during E low
        GATE_ACTIVE = 2'd2,  // clean select asserted
        GATE_SPENT  = 2'd3   // access ended by E fall, wait for raw high
    } gate_state_t;

    function automatic gate_state_t gate_next(
        input gate_state_t cur,
        input strobe_evt_t evt,
        input logic        raw_low
    );
        gate_state_t nxt;
        nxt = cur;
        case (cur)
            GATE_IDLE:   if (!evt.level && raw_low) nxt = GATE_ARMED;
            GATE_ARMED:  begin
                if (!raw_low)      nxt = GATE_IDLE;
                else if (evt.rise) nxt = GATE_ACTIVE;
            end
            GATE_ACTIVE: begin
                if (!raw_low)      nxt = GATE_IDLE;
                else if (evt.fall) nxt = GATE_SPENT;
            end
            GATE_SPENT:  if (!raw_low) nxt = GATE_IDLE;
            default:     nxt = GATE_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pgsel_strobe_edge.sv
module pgsel_strobe_edge
    import pgsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_e,
    output strobe_evt_t evt
);
    logic e_q;

    always_ff @(posedge clk) begin
        if (rst) e_q <= 1'b0;
        else     e_q <= strobe_e;
    end

    always_comb begin
        evt.level = strobe_e;
        evt.rise  = strobe_e & ~e_q;
        evt.fall  = ~strobe_e & e_q;
    end
endmodule

// File: rtl/pgsel_page_gate.sv
module pgsel_page_gate
    import pgsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  strobe_evt_t evt,
    input  logic        raw_n,
    output logic        clean_n
);
    gate_state_t st_q;
    gate_state_t st_d;

    always_comb begin
        st_d = gate_next(st_q, evt, ~raw_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= GATE_IDLE;
            clean_n <= 1'b1;
        end else begin
            st_q    <= st_d;
            clean_n <= (st_d != GATE_ACTIVE);
        end
    end
endmodule

// File: rtl/page_select_qualifier.sv
module page_select_qualifier
    import pgsel_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe_e,
    input  logic [NUM_PAGES-1:0] sel_raw_n,
    output logic [NUM_PAGES-1:0] sel_clean_n
);
    strobe_evt_t evt;

    pgsel_strobe_edge edge_i (
        .clk      (clk),
        .rst      (rst),
        .strobe_e (strobe_e),
        .evt      (evt)
    );

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        pgsel_page_gate gate_i (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt),
            .raw_n   (sel_raw_n[p]),
            .clean_n (sel_clean_n[p])
        );
    end
endmodule

// File: rtl/page_select_qualifier_chk.sv
module page_select_qualifier_chk #(
    parameter int unsigned NUM_PAGES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 strobe_e,
    input logic [NUM_PAGES-1:0] sel_raw_n,
    input logic [NUM_PAGES-1:0] sel_clean_n
);
    // R1
    rst_releases_chk: assert property (@(posedge clk)
        rst |=> (&sel_clean_n));

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_chk
        // R2
        set_only_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(sel_clean_n[p]) |-> ($past(strobe_e) && !$past(strobe_e, 2)
                && !$past(sel_raw_n[p]) && !$past(sel_raw_n[p], 2)));

        // R5
        hold_in_e_high_chk: assert property (@(posedge clk) disable iff (rst)
            (!sel_clean_n[p] && strobe_e && !sel_raw_n[p]) |=> !sel_clean_n[p]);

        // R6
        raw_release_chk: assert property (@(posedge clk) disable iff (rst)
            sel_raw_n[p] |=> sel_clean_n[p]);

        // R7
        e_fall_release_chk: assert property (@(posedge clk) disable iff (rst)
            (!strobe_e && $past(strobe_e)) |=> sel_clean_n[p]);
    end
endmodule

bind page_select_qualifier page_select_qualifier_chk #(
    .NUM_PAGES (NUM_PAGES)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .strobe_e    (strobe_e),
    .sel_raw_n   (sel_raw_n),
    .sel_clean_n (sel_clean_n)
);

// File: tb/page_select_qualifier_tb.sv
module page_select_qualifier_tb_top;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_e = 1'b0;
    logic [NP-1:0] sel_raw_n = '1;
    logic [NP-1:0] sel_clean_n;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R1";

    // reference model: 0 idle, 1 armed, 2 active, 3 spent
    int   mst [NP];
    bit   mclean [NP];
    bit   me_q;
    int   acc [NP];
    bit   dprev [NP];

    always #4 clk = ~clk;

    page_select_qualifier #(.NUM_PAGES(NP)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .strobe_e    (strobe_e),
        .sel_raw_n   (sel_raw_n),
        .sel_clean_n (sel_clean_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_adv();
        bit rise, fall;
        rise = strobe_e && !me_q;
        fall = !strobe_e && me_q;
        for (int p = 0; p < NP; p++) begin
            bit rl;
            rl = !sel_raw_n[p];
            if (rst) begin
                mst[p] = 0;
            end else if (!rl) begin
                mst[p] = 0;
            end else if (mst[p] == 0) begin
                if (!strobe_e) mst[p] = 1;
            end else if (mst[p] == 1) begin
                if (rise) mst[p] = 2;
            end else if (mst[p] == 2) begin
                if (fall) mst[p] = 3;
            end
            mclean[p] = (mst[p] != 2);
        end
        me_q = rst ? 1'b0 : strobe_e;
    endtask

    // inputs set at negedge, sampled at posedge, results checked next negedge
    task automatic step(input logic e, input logic [NP-1:0] r);
        strobe_e  = e;
        sel_raw_n = r;
        @(negedge clk);
        model_adv();
        for (int p = 0; p < NP; p++) begin
            chk(cur_tag, sel_clean_n[p], mclean[p]);
            if (dprev[p] && !sel_clean_n[p]) acc[p]++;
            dprev[p] = sel_clean_n[p];
        end
    endtask

    task automatic phase(input logic e, input int n, input logic [NP-1:0] r);
        for (int i = 0; i < n; i++) step(e, r);
    endtask

    task automatic clr_acc();
        for (int p = 0; p < NP; p++) acc[p] = 0;
    endtask

    initial begin
        #(200000 * 8);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            mst[p] = 0; mclean[p] = 1; acc[p] = 0; dprev[p] = 1;
        end
        me_q = 0;
        @(negedge clk);
        // R1 reset state
        cur_tag = "R1";
        phase(1'b0, 3, 2'b00);
        chk("R1", sel_clean_n[0], 1'b1);
        chk("R1", sel_clean_n[1], 1'b1);
        rst = 1'b0;
        phase(1'b0, 4, 2'b11);

        // R2 R5 R7: normal access on page 0
        cur_tag = "R2"; clr_acc();
        phase(1'b0, 4, 2'b10);
        step(1'b1, 2'b10);
        chk("R2", sel_clean_n[0], 1'b0);
        cur_tag = "R5";
        phase(1'b1, 7, 2'b10);
        chk("R5", sel_clean_n[0], 1'b0);
        cur_tag = "R7";
        phase(1'b0, 4, 2'b11);
        chk_int("R2", acc[0], 1);

        // R3: glitch during E high
        cur_tag = "R3"; clr_acc();
        phase(1'b0, 4, 2'b11);
        phase(1'b1, 3, 2'b11);
        phase(1'b1, 2, 2'b10);
        phase(1'b1, 3, 2'b11);
        phase(1'b0, 8, 2'b11);
        chk_int("R3", acc[0], 0);

        // R4: pulse inside E low, gone before rise
        cur_tag = "R4"; clr_acc();
        phase(1'b0, 2, 2'b11);
        phase(1'b0, 3, 2'b10);
        phase(1'b0, 3, 2'b11);
        phase(1'b1, 8, 2'b11);
        phase(1'b0, 4, 2'b11);
        chk_int("R4", acc[0], 0);

        // R2 edge case: raw low only from the rise sample on
        cur_tag = "R2"; clr_acc();
        phase(1'b0, 4, 2'b11);
        phase(1'b1, 8, 2'b10);
        phase(1'b0, 4, 2'b11);
        chk_int("R2", acc[0], 0);

        // R9: double access
        cur_tag = "R9"; clr_acc();
        phase(1'b1, 4, 2'b11);
        phase(1'b1, 4, 2'b10);
        chk("R9", sel_clean_n[0], 1'b1);
        phase(1'b0, 8, 2'b10);
        phase(1'b1, 8, 2'b10);
        phase(1'b0, 4, 2'b11);
        chk_int("R9", acc[0], 1);

        // R6: raw release in mid E high
        cur_tag = "R6"; clr_acc();
        phase(1'b0, 4, 2'b10);
        phase(1'b1, 3, 2'b10);
        step(1'b1, 2'b11);
        chk("R6", sel_clean_n[0], 1'b1);
        phase(1'b1, 4, 2'b11);
        phase(1'b0, 4, 2'b11);
        chk_int("R6", acc[0], 1);

        // R7: raw held over two E periods gives one access
        cur_tag = "R7"; clr_acc();
        phase(1'b0, 4, 2'b10);
        phase(1'b1, 8, 2'b10);
        step(1'b0, 2'b10);
        chk("R7", sel_clean_n[0], 1'b1);
        phase(1'b0, 7, 2'b10);
        phase(1'b1, 8, 2'b10);
        phase(1'b0, 4, 2'b11);
        chk_int("R7", acc[0], 1);

        // R8: page 1 access, page 0 glitch in E high
        cur_tag = "R8"; clr_acc();
        phase(1'b0, 4, 2'b01);
        phase(1'b1, 2, 2'b01);
        phase(1'b1, 2, 2'b00);
        chk("R8", sel_clean_n[1], 1'b0);
        chk("R8", sel_clean_n[0], 1'b1);
        phase(1'b1, 4, 2'b01);
        phase(1'b0, 4, 2'b11);
        chk_int("R8", acc[1], 1);
        chk_int("R8", acc[0], 0);

        // R1: reset during an active access
        cur_tag = "R1";
        phase(1'b0, 4, 2'b00);
        phase(1'b1, 2, 2'b00);
        chk("R1", sel_clean_n[0], 1'b0);
        rst = 1'b1;
        step(1'b1, 2'b00);
        chk("R1", sel_clean_n[0], 1'b1);
        chk("R1", sel_clean_n[1], 1'b1);
        rst = 1'b0;
        phase(1'b1, 4, 2'b00);
        phase(1'b0, 4, 2'b11);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule